// File: doc/BRIEF.md
# Width-Selectable Word Packer and Splitter with Byte Reversal

This block sits between a narrow external port and a fixed 36-bit internal word path. It is made of two independent halves. The packing half takes transfers of 36, 18 or 9 bits and gathers them into full 36-bit words. The splitting half takes full 36-bit words and hands them out again as transfers of the width selected on its own side. Each half has its own width select and its own byte-reversal enable. The reversal treats a word as four 9-bit lanes and mirrors their order, which converts between big-endian and little-endian layouts.

Width selects may change while traffic is flowing. A new width is picked up only at a word boundary. On the packing side, the width is latched when the first piece of a word is accepted, and any partly gathered word is finished at that width. On the splitting side, the width is latched when a word is taken in. Every handshake uses valid/ready, and a transfer happens on a rising clock edge where both are high.

Top module: `width_funnel`

## Requirements
- R1: The width select code is decoded the same way on both sides: 2'b00 means 36 bits, 2'b01 means 18 bits, 2'b10 means 9 bits, and the reserved code 2'b11 behaves as 36 bits.
- R2: In 9-bit packing mode, four accepted transfers form one word. Bits [8:0] of the k-th transfer (k = 0..3) land in word bits [9k+8:9k], and the other input bits are ignored.
- R3: In 18-bit packing mode, two accepted transfers form one word. Bits [17:0] of the k-th transfer (k = 0..1) land in word bits [18k+17:18k], and the other input bits are ignored.
- R4: In 36-bit packing mode, every accepted transfer becomes one word unchanged. In every mode, the packed word shows on pk_valid_o/pk_data_o in the cycle after the edge that accepted its final piece.
- R5: When the reversal enable of a side is high, lane b (bits [9b+8:9b]) of the word moves to lane 3-b. The packing side samples in_swap_i with the final piece of the word. The splitting side samples out_swap_i when the word is taken in.
- R6: The splitting side presents a held word as 1, 2 or 4 pieces, least-significant piece first. Piece k holds word bits starting at k times the piece width, and out_data_o bits above the piece width are zero.
- R7: A width is fixed for the whole of a word. Changes on in_wsel_i after the first piece is accepted, and changes on out_wsel_i after the word is taken in, have no effect until that word is complete.
- R8: The two sides choose width and reversal independently of each other.
- R9: in_ready_o is high exactly when no packed word is pending or the pending word is being taken this cycle. A pending word keeps pk_valid_o high and pk_data_o stable until pk_ready_i takes it.
- R10: wd_ready_o is high exactly when no word is held or the last piece of the held word is taken this cycle. While out_valid_o is high and out_ready_i is low, out_data_o is stable.
- R11: After reset, pk_valid_o and out_valid_o are low and in_ready_o and wd_ready_o are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_wsel_i | input | 2 | Packing-side width select |
| in_swap_i | input | 1 | Packing-side lane reversal enable |
| in_valid_i | input | 1 | Narrow input piece valid |
| in_data_i | input | 36 | Narrow input piece, low-aligned |
| in_ready_o | output | 1 | Packing side can accept a piece |
| pk_valid_o | output | 1 | Packed word valid |
| pk_data_o | output | 36 | Packed word |
| pk_ready_i | input | 1 | Consumer takes packed word |
| wd_valid_i | input | 1 | Internal word valid for splitting |
| wd_data_i | input | 36 | Internal word for splitting |
| wd_ready_o | output | 1 | Splitting side can take a word |
| out_wsel_i | input | 2 | Splitting-side width select |
| out_swap_i | input | 1 | Splitting-side lane reversal enable |
| out_valid_o | output | 1 | Narrow output piece valid |
| out_data_o | output | 36 | Narrow output piece, low-aligned, zero above width |
| out_ready_i | input | 1 | Consumer takes output piece |

## Verification
The hardest case to reach is a width-select change that arrives partway through a word, while backpressure is holding either the packed word or the output piece. On the packing side, the stimulus drives the intended width only with the first piece of each word, then drives random codes (including the reserved one) on the select for every later piece. The reversal enable is random except on the final piece. Both consumer readies stall at random, so stalls overlap with half-built words. On the splitting side, the select and reversal enable change every cycle, and the expected pieces use only the values present at the edge where the word was taken.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
  typedef enum logic [1:0] {
    SZ_FULL = 2'd0,
    SZ_HALF = 2'd1,
    SZ_LANE = 2'd2
  } size_e;

  function automatic size_e decode_wsel(input logic [1:0] sel);
    case (sel)
      2'b01:   return SZ_HALF;
      2'b10:   return SZ_LANE;
      default: return SZ_FULL;  // 00 and reserved 11
    endcase
  endfunction
endpackage

// File: rtl/fn_lane_swap.sv
module fn_lane_swap #(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES
) (
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] rev;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign rev[b*LANE_W +: LANE_W] = word_i[(LANES-1-b)*LANE_W +: LANE_W];
  end

  assign word_o = en_i ? rev : word_i;
endmodule

// File: rtl/fn_packer.sv
module fn_packer
  import funnel_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned CNT_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wsel_i,
  input  logic              swap_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ready_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  input  logic              word_ready_i,
  output logic [CNT_W-1:0]  cnt_o,
  output size_e             size_o
);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(LANES - 1);

  logic [WORD_W-1:0] acc_q, word_q, merged, swapped;
  logic [CNT_W-1:0]  cnt_q;
  size_e             size_q, eff_size;
  logic              word_valid_q, slot_free, fire, last;

  // width is taken live only for the first piece of a word
  assign eff_size = (cnt_q == '0) ? decode_wsel(wsel_i) : size_q;

  always_comb begin
    case (eff_size)
      SZ_HALF: last = (cnt_q == LAST_HALF);
      SZ_LANE: last = (cnt_q == LAST_LANE);
      default: last = 1'b1;
    endcase
  end

  always_comb begin
    merged = acc_q;
    case (eff_size)
      SZ_HALF: merged[int'(cnt_q)*HALF_W +: HALF_W] = data_i[HALF_W-1:0];
      SZ_LANE: merged[int'(cnt_q)*LANE_W +: LANE_W] = data_i[LANE_W-1:0];
      default: merged = data_i;
    endcase
  end

  fn_lane_swap #(.LANE_W(LANE_W), .LANES(LANES)) u_swap (
    .en_i  (swap_i),
    .word_i(merged),
    .word_o(swapped)
  );

  assign slot_free = !word_valid_q || word_ready_i;
  assign ready_o   = slot_free;
  assign fire      = valid_i && slot_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      size_q <= SZ_FULL;
      word_q <= '0;
    end else if (fire) begin
      if (cnt_q == '0) size_q <= eff_size;
      if (last) begin
        word_q <= swapped;
        cnt_q  <= '0;
      end else begin
        acc_q <= merged;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            word_valid_q <= 1'b0;
    else if (fire && last)  word_valid_q <= 1'b1;
    else if (word_ready_i)  word_valid_q <= 1'b0;
  end

  assign word_valid_o = word_valid_q;
  assign word_data_o  = word_q;
  assign cnt_o        = cnt_q;
  assign size_o       = size_q;
endmodule

// File: rtl/fn_splitter.sv
module fn_splitter
  import funnel_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned CNT_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wsel_i,
  input  logic              swap_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              piece_valid_o,
  output logic [WORD_W-1:0] piece_data_o,
  input  logic              piece_ready_i,
  output size_e             size_o
);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(LANES - 1);

  logic [WORD_W-1:0] buf_q, swapped;
  logic [CNT_W-1:0]  cnt_q;
  size_e             size_q;
  logic              has_q, last, take, done, load;

  fn_lane_swap #(.LANE_W(LANE_W), .LANES(LANES)) u_swap (
    .en_i  (swap_i),
    .word_i(word_data_i),
    .word_o(swapped)
  );

  always_comb begin
    case (size_q)
      SZ_HALF: last = (cnt_q == LAST_HALF);
      SZ_LANE: last = (cnt_q == LAST_LANE);
      default: last = 1'b1;
    endcase
  end

  assign take         = has_q && piece_ready_i;
  assign done         = take && last;
  assign word_ready_o = !has_q || done;
  assign load         = word_valid_i && word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      has_q  <= 1'b0;
      buf_q  <= '0;
      cnt_q  <= '0;
      size_q <= SZ_FULL;
    end else if (load) begin
      has_q  <= 1'b1;
      buf_q  <= swapped;
      cnt_q  <= '0;
      size_q <= decode_wsel(wsel_i);
    end else if (done) begin
      has_q <= 1'b0;
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    piece_data_o = '0;
    case (size_q)
      SZ_HALF: piece_data_o[HALF_W-1:0] = buf_q[int'(cnt_q)*HALF_W +: HALF_W];
      SZ_LANE: piece_data_o[LANE_W-1:0] = buf_q[int'(cnt_q)*LANE_W +: LANE_W];
      default: piece_data_o = buf_q;
    endcase
  end

  assign piece_valid_o = has_q;
  assign size_o        = size_q;
endmodule

// File: rtl/width_funnel.sv
module width_funnel
  import funnel_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned CNT_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        in_wsel_i,
  input  logic              in_swap_i,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              pk_valid_o,
  output logic [WORD_W-1:0] pk_data_o,
  input  logic              pk_ready_i,
  input  logic              wd_valid_i,
  input  logic [WORD_W-1:0] wd_data_i,
  output logic              wd_ready_o,
  input  logic [1:0]        out_wsel_i,
  input  logic              out_swap_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic [CNT_W-1:0] pk_cnt;
  size_e            pk_size, up_size;

  fn_packer #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wsel_i      (in_wsel_i),
    .swap_i      (in_swap_i),
    .valid_i     (in_valid_i),
    .data_i      (in_data_i),
    .ready_o     (in_ready_o),
    .word_valid_o(pk_valid_o),
    .word_data_o (pk_data_o),
    .word_ready_i(pk_ready_i),
    .cnt_o       (pk_cnt),
    .size_o      (pk_size)
  );

  fn_splitter #(.LANE_W(LANE_W), .LANES(LANES)) u_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wsel_i       (out_wsel_i),
    .swap_i       (out_swap_i),
    .word_valid_i (wd_valid_i),
    .word_data_i  (wd_data_i),
    .word_ready_o (wd_ready_o),
    .piece_valid_o(out_valid_o),
    .piece_data_o (out_data_o),
    .piece_ready_i(out_ready_i),
    .size_o       (up_size)
  );
endmodule

// File: rtl/width_funnel_chk.sv
module width_funnel_chk
  import funnel_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned CNT_W  = $clog2(LANES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              pk_valid_o,
  input logic [WORD_W-1:0] pk_data_o,
  input logic              pk_ready_i,
  input logic              wd_ready_o,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic [CNT_W-1:0]  pk_cnt,
  input size_e             pk_size,
  input size_e             up_size
);
  a_r9_stall_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_valid_o && !pk_ready_i |-> !in_ready_o);

  a_r9_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_valid_o && !pk_ready_i |=> pk_valid_o && $stable(pk_data_o));

  a_r10_piece_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r7_pack_width_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_cnt != '0 |=> pk_cnt == '0 || $stable(pk_size));

  a_r7_split_width_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !wd_ready_o |=> $stable(up_size));

  a_r6_lane_zero_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && up_size == SZ_LANE |-> out_data_o[WORD_W-1:LANE_W] == '0);

  a_r6_half_zero_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && up_size == SZ_HALF |-> out_data_o[WORD_W-1:HALF_W] == '0);
endmodule

bind width_funnel width_funnel_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/width_funnel_test.sv
module width_funnel_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  in_wsel_i = '0;
  logic        in_swap_i = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [35:0] in_data_i = '0;
  logic        in_ready_o;
  logic        pk_valid_o;
  logic [35:0] pk_data_o;
  logic        pk_ready_i = 1'b0;
  logic        wd_valid_i = 1'b0;
  logic [35:0] wd_data_i = '0;
  logic        wd_ready_o;
  logic [1:0]  out_wsel_i = '0;
  logic        out_swap_i = 1'b0;
  logic        out_valid_o;
  logic [35:0] out_data_o;
  logic        out_ready_i = 1'b0;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  width_funnel uut (.*);

  function automatic int pieces_of(input logic [1:0] sel);
    return (sel == 2'b01) ? 2 : (sel == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] rev_lanes(input logic [35:0] w);
    return {w[8:0], w[17:9], w[26:18], w[35:27]};
  endfunction

  function automatic logic [35:0] piece_of(input logic [35:0] w, input int n, input int k);
    if (n == 2) return {18'd0, w[k*18 +: 18]};
    if (n == 4) return {27'd0, w[k*9 +: 9]};
    return w;
  endfunction

  function automatic string tag_of(input logic [1:0] sel, input bit sw, input bit pack);
    string s;
    if (!pack)             s = "R6";
    else if (sel == 2'b01) s = "R3";
    else if (sel == 2'b10) s = "R2";
    else                   s = "R4";
    if (sel == 2'b11) s = {s, " R1"};
    if (sw) s = {s, " R5"};
    return {s, " R7 R8"};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_pack(input int cycles);
    logic [35:0] pc[4];
    logic [35:0] exp_q[$];
    string       tag_q[$];
    logic [1:0]  sel;
    bit          sw;
    int          n, pi;
    logic [35:0] w;
    sel = 2'(($urandom % 4)); n = pieces_of(sel); sw = 1'($urandom % 2); pi = 0;
    for (int i = 0; i < 4; i++) pc[i] = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      pk_ready_i = ($urandom % 4) != 0;
      in_valid_i = ($urandom % 5) != 0;
      in_data_i  = pc[pi];
      in_wsel_i  = (pi == 0) ? sel : 2'($urandom % 4);
      in_swap_i  = (pi == n - 1) ? sw : 1'($urandom % 2);
      #1;
      check(pk_valid_o == (exp_q.size() != 0), "R9 R4 word valid", 36'(pk_valid_o),
            36'(exp_q.size() != 0));
      check(in_ready_o == (exp_q.size() == 0 || pk_ready_i), "R9 input ready",
            36'(in_ready_o), 36'(exp_q.size() == 0 || pk_ready_i));
      if (pk_valid_o && pk_ready_i && exp_q.size() != 0) begin
        check(pk_data_o == exp_q[0], tag_q[0], pk_data_o, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (in_valid_i && in_ready_o) begin
        pi++;
        if (pi == n) begin
          if (n == 1)      w = pc[0];
          else if (n == 2) w = {pc[1][17:0], pc[0][17:0]};
          else             w = {pc[3][8:0], pc[2][8:0], pc[1][8:0], pc[0][8:0]};
          if (sw) w = rev_lanes(w);
          exp_q.push_back(w);
          tag_q.push_back(tag_of(sel, sw, 1'b1));
          sel = 2'(($urandom % 4)); n = pieces_of(sel); sw = 1'($urandom % 2); pi = 0;
          for (int i = 0; i < 4; i++) pc[i] = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
        end
      end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic run_split(input int cycles);
    logic [35:0] word_q[$];
    int          n_q[$];
    string       tag_q[$];
    int          pc;
    bit          ev, lst;
    logic [35:0] ep;
    pc = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      out_ready_i = ($urandom % 3) != 0;
      wd_valid_i  = ($urandom % 3) != 0;
      wd_data_i   = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      out_wsel_i  = 2'($urandom % 4);
      out_swap_i  = 1'($urandom % 2);
      #1;
      ev  = word_q.size() != 0;
      lst = ev && (pc == n_q[0] - 1);
      check(out_valid_o == ev, "R10 piece valid", 36'(out_valid_o), 36'(ev));
      check(wd_ready_o == (!ev || (out_ready_i && lst)), "R10 word ready",
            36'(wd_ready_o), 36'(!ev || (out_ready_i && lst)));
      if (ev) begin
        ep = piece_of(word_q[0], n_q[0], pc);
        check(out_data_o == ep, tag_q[0], out_data_o, ep);
        if (out_ready_i) begin
          pc++;
          if (lst) begin
            void'(word_q.pop_front());
            void'(n_q.pop_front());
            void'(tag_q.pop_front());
            pc = 0;
          end
        end
      end
      if (wd_valid_i && wd_ready_o) begin
        word_q.push_back(out_swap_i ? rev_lanes(wd_data_i) : wd_data_i);
        n_q.push_back(pieces_of(out_wsel_i));
        tag_q.push_back(tag_of(out_wsel_i, out_swap_i, 1'b0));
      end
    end
    @(negedge clk_i);
    wd_valid_i = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(!pk_valid_o, "R11 packed valid after reset", 36'(pk_valid_o), 36'd0);
    check(!out_valid_o, "R11 piece valid after reset", 36'(out_valid_o), 36'd0);
    check(in_ready_o, "R11 input ready after reset", 36'(in_ready_o), 36'd1);
    check(wd_ready_o, "R11 word ready after reset", 36'(wd_ready_o), 36'd1);
    fork
      run_pack(6000);
      run_split(6000);
    join
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end
endmodule